// File: doc/BRIEF.md
# Software-Managed Private Data Cache Controller

This block is the controller of a small private data cache that sits beside one core in a multiprocessor with no hardware coherence. The core issues byte loads and stores. It also issues explicit commands that push modified data toward the shared next level or drop stale lines, one line at a time or across the whole cache. The controller keeps one valid bit per line and one dirty bit per byte. Every write toward the next level carries a byte mask that selects only the modified bytes. Two cores that each modify different bytes of one line therefore never overwrite each other's bytes at the shared level.

The cache is direct-mapped, with `SETS` lines of `LINE_BYTES` bytes each. Core requests use a valid/ready handshake. Each request ends with a one-cycle `rsp_valid` pulse, which also marks the end of a whole-cache walk. Misses fetch the full line over a refill port. Any dirty victim is written back with its mask before the refill request goes out.

The state machine has five states. ST_IDLE accepts requests and finishes hits and no-op commands there. ST_EVICT writes back a dirty victim. ST_REFILL waits for line data. ST_FLUSH writes back the addressed line for a single-line command. ST_WALK visits every set for the whole-cache commands. The transitions are:

- IDLE→EVICT on a miss with a dirty victim.
- IDLE→REFILL on a miss with a clean or empty victim.
- EVICT→REFILL when the downstream write is accepted.
- REFILL→IDLE when the refill data arrives.
- IDLE→FLUSH on a line command that hits a line with dirty bytes.
- FLUSH→IDLE when the write is accepted.
- IDLE→WALK on a whole-cache command.
- WALK→IDLE after the last set.

Top module: `ninc_l1_ctrl`

## Requirements
- R1: After reset every line is invalid and clean, `req_ready` is 1, and `wb_valid`, `rf_req` and `rsp_valid` are 0.
- R2: The op code on `req_op` is 0 for load, 1 for store, 2 for line writeback, 3 for line invalidate, 4 for writeback of all lines and 5 for invalidate of all lines. A load that hits returns the addressed byte on `rsp_data`, with `rsp_valid` high in the cycle after acceptance, and causes no downstream or refill traffic.
- R3: A load or store miss raises `rf_req` with the line address (`addr >> log2(LINE_BYTES)`) and installs the returned line as valid. A load then returns the addressed byte. A store merges its byte and marks only that byte dirty.
- R4: A store that hits writes its byte, sets that byte's dirty bit and completes in the cycle after acceptance.
- R5: A line writeback of a line with dirty bytes issues exactly one downstream write. It carries the line address, and `wb_mask` bit b is set only for dirty byte b, so bytes the core did not modify are left unchanged at the next level. Afterwards the line stays valid with no dirty bits.
- R6: A line invalidate of a line with dirty bytes first writes back those bytes with their mask, then clears the valid bit, so the next access to that line misses.
- R7: A line writeback or invalidate that targets an absent line or a clean line completes in the cycle after acceptance with no downstream write. Invalidating a clean resident line still clears its valid bit.
- R8: Writeback of all lines visits the sets in increasing index order, one per cycle while the next level is ready. It issues one masked write per line with dirty bytes, leaves every line valid, and pulses `rsp_valid` exactly `SETS` cycles after acceptance when `wb_ready` stays high.
- R9: Invalidate of all lines writes back every dirty byte, then leaves every line invalid. It takes `SETS` cycles when `wb_ready` stays high.
- R10: A miss whose victim line holds dirty bytes writes the victim back with its mask before `rf_req` is raised. The two are never high together.
- R11: `req_ready` is 0 while a downstream write is pending. While `wb_valid` is high and `wb_ready` low, the write's address, data and mask hold steady.
- R12: Op codes 6 and 7 complete in the cycle after acceptance and change no line and no output other than `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Controller can accept a request |
| req_op | input | 3 | Operation code (see R2, R12) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Store byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 8 | Load result, valid with `rsp_valid` for loads |
| wb_valid | output | 1 | Downstream write pending |
| wb_ready | input | 1 | Next level accepts the write |
| wb_addr | output | ADDR_W-log2(LINE_BYTES) | Line address of the write |
| wb_data | output | 8*LINE_BYTES | Full line data |
| wb_mask | output | LINE_BYTES | Byte mask of modified bytes |
| rf_req | output | 1 | Refill request, held until answered |
| rf_addr | output | ADDR_W-log2(LINE_BYTES) | Line address to fetch |
| rf_resp_valid | input | 1 | Refill data present |
| rf_resp_data | input | 8*LINE_BYTES | Refill line data |

## Verification
The bench targets false sharing. It changes one byte at the next level behind the cache's back, then writes back a neighbouring byte. A controller that wrote the whole line or used a wrong mask would put the stale byte back. It checks that a line writeback leaves the line valid and clean, since a design that skipped clearing the dirty bits would send a second write on the next command. It checks that a dirty victim is written before the refill and that whole-cache walks go in index order and finish in exactly `SETS` cycles. It also holds `wb_ready` low to see that the core port stalls and the write stays stable. A long random mix with random downstream and refill stalls follows. It is checked against a flat memory image and a small model of line state.

// File: rtl/ninc_pkg.sv
package ninc_pkg;

    typedef enum logic [2:0] {
        OP_LOAD    = 3'd0,
        OP_STORE   = 3'd1,
        OP_WB      = 3'd2,
        OP_INV     = 3'd3,
        OP_WB_ALL  = 3'd4,
        OP_INV_ALL = 3'd5,
        OP_RSV6    = 3'd6,
        OP_RSV7    = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVICT,
        ST_REFILL,
        ST_FLUSH,
        ST_WALK
    } state_e;

endpackage

// File: rtl/ninc_line_store.sv
module ninc_line_store #(
    parameter int SETS       = 8,
    parameter int LINE_BYTES = 4,
    parameter int TAG_W      = 7,
    parameter int IDX_W      = $clog2(SETS),
    parameter int LINE_W     = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic                  rd_valid,
    output logic [TAG_W-1:0]      rd_tag,
    output logic [LINE_W-1:0]     rd_data,
    output logic [LINE_BYTES-1:0] rd_dirty,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic                  wr_valid,
    input  logic [TAG_W-1:0]      wr_tag,
    input  logic [LINE_W-1:0]     wr_data,
    input  logic [LINE_BYTES-1:0] wr_dirty
);

    logic                  valid_q [SETS];
    logic [TAG_W-1:0]      tag_q   [SETS];
    logic [LINE_W-1:0]     data_q  [SETS];
    logic [LINE_BYTES-1:0] dirty_q [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= 1'b0;
                tag_q[s]   <= '0;
                data_q[s]  <= '0;
                dirty_q[s] <= '0;
            end
        end else if (wr_en) begin
            valid_q[wr_idx] <= wr_valid;
            tag_q[wr_idx]   <= wr_tag;
            data_q[wr_idx]  <= wr_data;
            dirty_q[wr_idx] <= wr_dirty;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];

endmodule

// File: rtl/ninc_byte_merge.sv
module ninc_byte_merge #(
    parameter int LINE_BYTES = 4,
    parameter int OFF_W      = $clog2(LINE_BYTES),
    parameter int LINE_W     = LINE_BYTES * 8
) (
    input  logic [LINE_W-1:0]     in_data,
    input  logic [LINE_BYTES-1:0] in_dirty,
    input  logic [OFF_W-1:0]      sel_off,
    input  logic [7:0]            new_byte,
    output logic [LINE_W-1:0]     out_data,
    output logic [LINE_BYTES-1:0] out_dirty
);

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
        logic hit_b;
        assign hit_b              = (sel_off == OFF_W'(b));
        assign out_data[b*8 +: 8] = hit_b ? new_byte : in_data[b*8 +: 8];
        assign out_dirty[b]       = in_dirty[b] | hit_b;
    end

endmodule

// File: rtl/ninc_l1_ctrl.sv
module ninc_l1_ctrl
    import ninc_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int LINE_BYTES = 4,
    parameter int SETS       = 8
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    req_valid,
    output logic                                    req_ready,
    input  logic [2:0]                              req_op,
    input  logic [ADDR_W-1:0]                       req_addr,
    input  logic [7:0]                              req_wdata,
    output logic                                    rsp_valid,
    output logic [7:0]                              rsp_data,
    output logic                                    wb_valid,
    input  logic                                    wb_ready,
    output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]    wb_addr,
    output logic [LINE_BYTES*8-1:0]                 wb_data,
    output logic [LINE_BYTES-1:0]                   wb_mask,
    output logic                                    rf_req,
    output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]    rf_addr,
    input  logic                                    rf_resp_valid,
    input  logic [LINE_BYTES*8-1:0]                 rf_resp_data
);

    localparam int OFF_W   = $clog2(LINE_BYTES);
    localparam int IDX_W   = $clog2(SETS);
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
    localparam int LINE_AW = ADDR_W - OFF_W;
    localparam int LINE_W  = LINE_BYTES * 8;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SETS - 1);

    function automatic logic [7:0] pick_byte(input logic [LINE_W-1:0] d,
                                             input logic [OFF_W-1:0]  o);
        logic [7:0] r;
        r = d[7:0];
        for (int b = 0; b < LINE_BYTES; b++) begin
            if (o == OFF_W'(b)) r = d[b*8 +: 8];
        end
        return r;
    endfunction

    state_e                state_q, state_d;
    op_e                   op_q, op_d, req_op_e;
    logic [ADDR_W-1:0]     addr_q, addr_d;
    logic [7:0]            wdata_q, wdata_d;
    logic [IDX_W-1:0]      cur_idx_q, cur_idx_d;
    logic                  rsp_q, rsp_d;
    logic [7:0]            rsp_data_q, rsp_data_d;

    logic [OFF_W-1:0]      req_off, q_off;
    logic [IDX_W-1:0]      req_idx, rd_idx;
    logic [TAG_W-1:0]      req_tag, q_tag;

    logic                  rd_valid;
    logic [TAG_W-1:0]      rd_tag;
    logic [LINE_W-1:0]     rd_data;
    logic [LINE_BYTES-1:0] rd_dirty;

    logic                  st_we, st_wr_valid;
    logic [TAG_W-1:0]      st_wr_tag;
    logic [LINE_W-1:0]     st_wr_data;
    logic [LINE_BYTES-1:0] st_wr_dirty;

    logic [LINE_W-1:0]     mg_base_data, mg_data;
    logic [LINE_BYTES-1:0] mg_base_dirty, mg_dirty;
    logic [OFF_W-1:0]      mg_off;
    logic [7:0]            mg_byte;

    logic                  req_hit, line_dirty, walk_step;

    assign req_op_e  = op_e'(req_op);
    assign req_off   = req_addr[OFF_W-1:0];
    assign req_idx   = req_addr[OFF_W +: IDX_W];
    assign req_tag   = req_addr[ADDR_W-1 -: TAG_W];
    assign q_off     = addr_q[OFF_W-1:0];
    assign q_tag     = addr_q[ADDR_W-1 -: TAG_W];
    assign rd_idx    = (state_q == ST_IDLE) ? req_idx : cur_idx_q;
    assign req_hit   = rd_valid && (rd_tag == req_tag);
    assign line_dirty = rd_valid && (rd_dirty != '0);

    ninc_line_store #(
        .SETS       (SETS),
        .LINE_BYTES (LINE_BYTES),
        .TAG_W      (TAG_W),
        .IDX_W      (IDX_W),
        .LINE_W     (LINE_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_data  (rd_data),
        .rd_dirty (rd_dirty),
        .wr_en    (st_we),
        .wr_idx   (rd_idx),
        .wr_valid (st_wr_valid),
        .wr_tag   (st_wr_tag),
        .wr_data  (st_wr_data),
        .wr_dirty (st_wr_dirty)
    );

    assign mg_base_data  = (state_q == ST_REFILL) ? rf_resp_data : rd_data;
    assign mg_base_dirty = (state_q == ST_REFILL) ? '0 : rd_dirty;
    assign mg_off        = (state_q == ST_IDLE) ? req_off : q_off;
    assign mg_byte       = (state_q == ST_IDLE) ? req_wdata : wdata_q;

    ninc_byte_merge #(
        .LINE_BYTES (LINE_BYTES),
        .OFF_W      (OFF_W),
        .LINE_W     (LINE_W)
    ) u_merge (
        .in_data   (mg_base_data),
        .in_dirty  (mg_base_dirty),
        .sel_off   (mg_off),
        .new_byte  (mg_byte),
        .out_data  (mg_data),
        .out_dirty (mg_dirty)
    );

    // State and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            op_q       <= OP_LOAD;
            addr_q     <= '0;
            wdata_q    <= '0;
            cur_idx_q  <= '0;
            rsp_q      <= 1'b0;
            rsp_data_q <= '0;
        end else begin
            state_q    <= state_d;
            op_q       <= op_d;
            addr_q     <= addr_d;
            wdata_q    <= wdata_d;
            cur_idx_q  <= cur_idx_d;
            rsp_q      <= rsp_d;
            rsp_data_q <= rsp_data_d;
        end
    end

    // Next state, line updates and handshake outputs
    always_comb begin
        state_d     = state_q;
        op_d        = op_q;
        addr_d      = addr_q;
        wdata_d     = wdata_q;
        cur_idx_d   = cur_idx_q;
        rsp_d       = 1'b0;
        rsp_data_d  = rsp_data_q;
        req_ready   = 1'b0;
        wb_valid    = 1'b0;
        rf_req      = 1'b0;
        walk_step   = 1'b0;
        st_we       = 1'b0;
        st_wr_valid = rd_valid;
        st_wr_tag   = rd_tag;
        st_wr_data  = rd_data;
        st_wr_dirty = rd_dirty;

        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    op_d      = req_op_e;
                    addr_d    = req_addr;
                    wdata_d   = req_wdata;
                    cur_idx_d = req_idx;
                    unique case (req_op_e)
                        OP_LOAD, OP_STORE: begin
                            if (req_hit) begin
                                rsp_d = 1'b1;
                                if (req_op_e == OP_LOAD) begin
                                    rsp_data_d = pick_byte(rd_data, req_off);
                                end else begin
                                    st_we       = 1'b1;
                                    st_wr_data  = mg_data;
                                    st_wr_dirty = mg_dirty;
                                end
                            end else if (line_dirty) begin
                                state_d = ST_EVICT;
                            end else begin
                                state_d = ST_REFILL;
                            end
                        end
                        OP_WB, OP_INV: begin
                            if (req_hit && rd_dirty != '0) begin
                                state_d = ST_FLUSH;
                            end else begin
                                rsp_d = 1'b1;
                                if (req_hit && req_op_e == OP_INV) begin
                                    st_we       = 1'b1;
                                    st_wr_valid = 1'b0;
                                end
                            end
                        end
                        OP_WB_ALL, OP_INV_ALL: begin
                            cur_idx_d = '0;
                            state_d   = ST_WALK;
                        end
                        default: rsp_d = 1'b1;
                    endcase
                end
            end
            ST_EVICT: begin
                wb_valid = 1'b1;
                if (wb_ready) begin
                    st_we       = 1'b1;
                    st_wr_valid = 1'b0;
                    st_wr_dirty = '0;
                    state_d     = ST_REFILL;
                end
            end
            ST_REFILL: begin
                rf_req = 1'b1;
                if (rf_resp_valid) begin
                    st_we       = 1'b1;
                    st_wr_valid = 1'b1;
                    st_wr_tag   = q_tag;
                    if (op_q == OP_STORE) begin
                        st_wr_data  = mg_data;
                        st_wr_dirty = mg_dirty;
                    end else begin
                        st_wr_data  = rf_resp_data;
                        st_wr_dirty = '0;
                        rsp_data_d  = pick_byte(rf_resp_data, q_off);
                    end
                    rsp_d   = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_FLUSH: begin
                wb_valid = 1'b1;
                if (wb_ready) begin
                    st_we       = 1'b1;
                    st_wr_dirty = '0;
                    st_wr_valid = (op_q != OP_INV);
                    rsp_d       = 1'b1;
                    state_d     = ST_IDLE;
                end
            end
            ST_WALK: begin
                if (line_dirty) begin
                    wb_valid  = 1'b1;
                    walk_step = wb_ready;
                    if (wb_ready) begin
                        st_we       = 1'b1;
                        st_wr_dirty = '0;
                        st_wr_valid = (op_q != OP_INV_ALL);
                    end
                end else begin
                    walk_step = 1'b1;
                    if (op_q == OP_INV_ALL) begin
                        st_we       = 1'b1;
                        st_wr_valid = 1'b0;
                        st_wr_dirty = '0;
                    end
                end
                if (walk_step) begin
                    if (cur_idx_q == LAST_IDX) begin
                        rsp_d   = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        cur_idx_d = cur_idx_q + IDX_W'(1);
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign wb_addr   = {rd_tag, cur_idx_q};
    assign wb_data   = rd_data;
    assign wb_mask   = rd_dirty;
    assign rf_addr   = addr_q[ADDR_W-1:OFF_W];
    assign rsp_valid = rsp_q;
    assign rsp_data  = rsp_data_q;

    // R11: the core port stalls while a downstream write is pending
    p_stall_on_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !req_ready);

    // R11: a stalled downstream write keeps its contents
    p_write_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) &&
                                     $stable(wb_mask) && $stable(wb_data)));

    // R5: only lines with modified bytes are ever written downstream
    p_mask_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_mask != '0));

    // R10: victim writeback and refill never overlap
    p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_valid && rf_req));

    // R3: refill data completes the request in the next cycle
    p_refill_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req && rf_resp_valid) |=> (rsp_valid && !rf_req));

    // R2: a completion pulse lasts one cycle unless a new request was accepted
    p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !(req_valid && req_ready)) |=> !rsp_valid);

endmodule

// File: tb/ninc_l1_ctrl_bench.sv
`timescale 1ns/1ps
module ninc_l1_ctrl_bench;

    localparam int ADDR_W = 12;
    localparam int LB     = 4;
    localparam int SETS   = 8;
    localparam int LAW    = ADDR_W - 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [2:0]      req_op = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [7:0]      req_wdata = '0;
    logic            rsp_valid;
    logic [7:0]      rsp_data;
    logic            wb_valid;
    logic            wb_ready = 1'b0;
    logic [LAW-1:0]  wb_addr;
    logic [LB*8-1:0] wb_data;
    logic [LB-1:0]   wb_mask;
    logic            rf_req;
    logic [LAW-1:0]  rf_addr;
    logic            rf_resp_valid = 1'b0;
    logic [LB*8-1:0] rf_resp_data = '0;

    always #2 clk = ~clk;

    ninc_l1_ctrl #(.ADDR_W(ADDR_W), .LINE_BYTES(LB), .SETS(SETS)) u_ninc_l1_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
        .wb_data(wb_data), .wb_mask(wb_mask),
        .rf_req(rf_req), .rf_addr(rf_addr),
        .rf_resp_valid(rf_resp_valid), .rf_resp_data(rf_resp_data)
    );

    logic [7:0] mem    [256];
    logic [7:0] golden [256];
    int  mv [SETS];
    int  mt [SETS];
    int  md [SETS];
    int  n_chk = 0, n_err = 0;
    int  wb_cnt = 0, rf_cnt = 0, cyc = 0, wb_cyc = 0, rf_cyc = 0;
    int  last_mask = 0, last_waddr = 0;
    int  wlog [8];
    int  log_n = 0;
    bit  hold_wb = 1'b0, rnd_wb = 1'b0, rnd_rf = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Next level: masked write sink and refill source
    always @(posedge clk) begin
        cyc++;
        if (rst_n && wb_valid && wb_ready) begin
            for (int b = 0; b < LB; b++)
                if (wb_mask[b]) mem[{wb_addr[5:0], 2'(b)}] = wb_data[b*8 +: 8];
            wb_cnt++;
            wb_cyc = cyc;
            last_mask = int'(wb_mask);
            last_waddr = int'(wb_addr);
            if (log_n < 8) begin wlog[log_n] = int'(wb_addr); log_n++; end
        end
        if (rst_n && rf_req && rf_resp_valid) begin
            rf_cnt++;
            rf_cyc = cyc;
        end
    end

    always @(negedge clk) begin
        wb_ready <= hold_wb ? 1'b0 : (rnd_wb ? 1'($urandom % 2) : 1'b1);
        rf_resp_valid <= rf_req && (rnd_rf ? (($urandom % 3) != 0) : 1'b1);
        for (int b = 0; b < LB; b++)
            rf_resp_data[b*8 +: 8] <= mem[{rf_addr[5:0], 2'(b)}];
    end

    task automatic do_op(input int op, input int a, input int wd,
                         output int data, output int lat, output int dwb, output int drf);
        int w0, r0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        w0 = wb_cnt; r0 = rf_cnt;
        req_valid = 1'b1; req_op = 3'(op); req_addr = ADDR_W'(a); req_wdata = 8'(wd);
        @(posedge clk); #1;
        req_valid = 1'b0;
        lat = 0;
        while (!rsp_valid && lat < 3000) begin @(posedge clk); #1; lat++; end
        if (lat >= 3000) chk(1'b0, "R2", "completion timeout", lat, 0);
        data = int'(rsp_data);
        dwb = wb_cnt - w0; drf = rf_cnt - r0;
        if (op == 1) golden[a] = 8'(wd);
    endtask

    task automatic model_step(input int op, input int a, output int ewb, output int erf,
                              output int emask);
        int idx, tag, off;
        bit hit;
        idx = (a >> 2) & 7; tag = a >> 5; off = a & 3;
        hit = (mv[idx] != 0) && (mt[idx] == tag);
        ewb = 0; erf = 0; emask = 0;
        case (op)
            0, 1: begin
                if (!hit) begin
                    if (mv[idx] != 0 && md[idx] != 0) begin ewb = 1; emask = md[idx]; end
                    erf = 1; mv[idx] = 1; mt[idx] = tag; md[idx] = 0;
                end
                if (op == 1) md[idx] = md[idx] | (1 << off);
            end
            2, 3: if (hit) begin
                if (md[idx] != 0) begin ewb = 1; emask = md[idx]; end
                md[idx] = 0;
                if (op == 3) mv[idx] = 0;
            end
            4, 5: for (int s = 0; s < SETS; s++) begin
                if (mv[s] != 0 && md[s] != 0) ewb++;
                md[s] = 0;
                if (op == 5) mv[s] = 0;
            end
            default: ;
        endcase
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "WATCHDOG", "run did not end", cyc, 200000);
        summary();
        $finish;
    end

    initial begin
        int d, lat, dwb, drf, ewb, erf, em, op, a, bad;
        bit ok;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) begin mem[i] = 8'(i * 7 + 3); golden[i] = mem[i]; end
        for (int s = 0; s < SETS; s++) begin mv[s] = 0; mt[s] = 0; md[s] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R1: reset state
        chk(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
        chk(!wb_valid && !rf_req && !rsp_valid, "R1", "idle outputs after reset",
            int'({wb_valid, rf_req, rsp_valid}), 0);

        // R3: load miss refills
        do_op(0, 'h05, 0, d, lat, dwb, drf);
        chk(drf == 1 && dwb == 0, "R3", "load miss traffic", drf, 1);
        chk(d == int'(golden['h05]), "R3", "load miss data", d, int'(golden['h05]));
        // R2: load hit
        do_op(0, 'h06, 0, d, lat, dwb, drf);
        chk(lat == 0 && drf == 0 && dwb == 0, "R2", "load hit latency", lat, 0);
        chk(d == int'(golden['h06]), "R2", "load hit data", d, int'(golden['h06]));
        // R4: store hit
        do_op(1, 'h07, 'h5A, d, lat, dwb, drf);
        chk(lat == 0 && dwb == 0 && drf == 0, "R4", "store hit latency", lat, 0);
        do_op(0, 'h07, 0, d, lat, dwb, drf);
        chk(d == 'h5A, "R4", "read back stored byte", d, 'h5A);

        // R3/R5: store miss then masked line writeback
        do_op(1, 'h21, 'h77, d, lat, dwb, drf);
        chk(drf == 1, "R3", "store miss refill", drf, 1);
        do_op(2, 'h21, 0, d, lat, dwb, drf);
        chk(dwb == 1 && last_mask == 'b0010 && last_waddr == 8, "R5", "single-byte mask",
            last_mask, 'b0010);
        chk(mem['h21] == 8'h77, "R5", "written byte at next level", int'(mem['h21]), 'h77);
        do_op(2, 'h21, 0, d, lat, dwb, drf);
        chk(dwb == 0 && lat == 0, "R7", "writeback of clean line", dwb, 0);
        do_op(0, 'h21, 0, d, lat, dwb, drf);
        chk(drf == 0 && d == 'h77, "R5", "line valid after writeback", drf, 0);

        // R5/R6: false sharing and invalidate with writeback
        do_op(1, 'h04, 'h11, d, lat, dwb, drf);
        mem['h05] = 8'hEE; golden['h05] = 8'hEE;
        do_op(3, 'h04, 0, d, lat, dwb, drf);
        chk(dwb == 1 && last_mask == 'b1001, "R6", "invalidate writes dirty bytes", last_mask, 'b1001);
        chk(mem['h05] == 8'hEE, "R5", "foreign byte preserved", int'(mem['h05]), 'hEE);
        chk(mem['h04] == 8'h11 && mem['h07] == 8'h5A, "R6", "own bytes written",
            int'(mem['h04]), 'h11);
        do_op(0, 'h05, 0, d, lat, dwb, drf);
        chk(drf == 1 && d == 'hEE, "R6", "miss after invalidate", d, 'hEE);

        // R7: invalidate clean and absent lines
        do_op(3, 'h05, 0, d, lat, dwb, drf);
        chk(dwb == 0 && lat == 0, "R7", "invalidate clean line", dwb, 0);
        do_op(0, 'h05, 0, d, lat, dwb, drf);
        chk(drf == 1, "R7", "clean invalidate cleared valid", drf, 1);
        do_op(3, 'hF0, 0, d, lat, dwb, drf);
        chk(dwb == 0 && drf == 0 && lat == 0, "R7", "invalidate absent line", lat, 0);
        // R12: reserved op codes
        do_op(6, 'h05, 'h99, d, lat, dwb, drf);
        do_op(7, 'h05, 'h99, d, lat, dwb, drf);
        chk(dwb == 0 && drf == 0 && lat == 0, "R12", "reserved op completes", lat, 0);
        do_op(0, 'h05, 0, d, lat, dwb, drf);
        chk(drf == 0 && d == 'hEE, "R12", "reserved op left line intact", d, 'hEE);

        // R10: dirty victim eviction precedes refill
        do_op(1, 'h09, 'h42, d, lat, dwb, drf);
        do_op(0, 'h49, 0, d, lat, dwb, drf);
        chk(dwb == 1 && drf == 1 && wb_cyc < rf_cyc, "R10", "victim write before refill",
            wb_cyc, rf_cyc);
        chk(last_mask == 'b0010 && last_waddr == 2 && mem['h09] == 8'h42, "R10",
            "victim mask", last_mask, 'b0010);

        // R11: stall on held downstream write
        do_op(1, 'h0D, 'h3C, d, lat, dwb, drf);
        hold_wb = 1'b1;
        @(negedge clk);
        @(negedge clk);
        a = wb_cnt;
        req_valid = 1'b1; req_op = 3'd2; req_addr = 'h0D;
        @(posedge clk); #1;
        req_valid = 1'b0;
        ok = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #1;
            if (!(wb_valid && !req_ready && wb_addr == 3 && wb_mask == 4'b0010)) ok = 1'b0;
        end
        chk(ok, "R11", "stall holds write and port", int'(req_ready), 0);
        hold_wb = 1'b0;
        lat = 0;
        while (!rsp_valid && lat < 100) begin @(posedge clk); #1; lat++; end
        chk(wb_cnt - a == 1 && mem['h0D] == 8'h3C, "R11", "write after release",
            wb_cnt - a, 1);

        // R8: walk order and latency
        do_op(1, 'h08, 'h61, d, lat, dwb, drf);
        do_op(1, 'h14, 'h62, d, lat, dwb, drf);
        log_n = 0;
        do_op(4, 0, 0, d, lat, dwb, drf);
        chk(dwb == 2 && wlog[0] == 2 && wlog[1] == 5, "R8", "walk order", wlog[0] * 16 + wlog[1], 'h25);
        chk(lat == SETS, "R8", "walk latency", lat, SETS);
        do_op(0, 'h14, 0, d, lat, dwb, drf);
        chk(drf == 0 && d == 'h62, "R8", "lines valid after walk", drf, 0);
        do_op(2, 'h14, 0, d, lat, dwb, drf);
        chk(dwb == 0, "R8", "lines clean after walk", dwb, 0);

        // R9: invalidate all
        do_op(1, 'h30, 'h63, d, lat, dwb, drf);
        do_op(5, 0, 0, d, lat, dwb, drf);
        chk(dwb == 1 && lat == SETS, "R9", "invalidate-all writes and latency", lat, SETS);
        bad = 0;
        for (int i = 0; i < 256; i++) if (mem[i] != golden[i]) bad++;
        chk(bad == 0, "R9", "next level matches core view", bad, 0);
        do_op(0, 'h14, 0, d, lat, dwb, drf);
        chk(drf == 1, "R9", "miss after invalidate-all", drf, 1);
        do_op(5, 0, 0, d, lat, dwb, drf);
        for (int s = 0; s < SETS; s++) begin mv[s] = 0; md[s] = 0; end

        // Random mix with downstream and refill stalls
        rnd_wb = 1'b1; rnd_rf = 1'b1;
        for (int n = 0; n < 400; n++) begin
            int r;
            r = int'($urandom % 100);
            op = (r < 40) ? 0 : (r < 72) ? 1 : (r < 80) ? 2 : (r < 88) ? 3 :
                 (r < 91) ? 4 : (r < 94) ? 5 : 6 + int'($urandom % 2);
            a = int'($urandom % 256);
            d = int'($urandom % 256);
            model_step(op, a, ewb, erf, em);
            do_op(op, a, d, d, lat, dwb, drf);
            chk(dwb == ewb, "R5", "random write count", dwb, ewb);
            chk(drf == erf, "R3", "random refill count", drf, erf);
            if (op == 0) chk(d == int'(golden[a]), "R2", "random load data", d, int'(golden[a]));
            if (ewb == 1 && op < 4) chk(last_mask == em, "R5", "random write mask", last_mask, em);
            if (op < 4 && ewb == 0 && erf == 0)
                chk(lat == 0, "R7", "random one-cycle completion", lat, 0);
        end
        do_op(5, 0, 0, d, lat, dwb, drf);
        bad = 0;
        for (int i = 0; i < 256; i++) if (mem[i] != golden[i]) bad++;
        chk(bad == 0, "R9", "final next-level image", bad, 0);

        summary();
        $finish;
    end

endmodule